// File: doc/BRIEF.md
# Debug Memory Command Engine

This block sits behind the serial front end of an on-chip debug port. It takes commands that have already been deserialized: an 8-bit opcode with, for memory commands, a 16-bit address and a 16-bit data word. It decodes each command and runs it. Memory commands become one transfer on a 16-bit target bus. Control commands change the completion-handshake state or ask the processor to enter background mode.

For each memory transfer the engine drives a window-select line. This line decides whether the debug register and firmware window overlays the normal memory map for that transfer only. Byte transfers are steered onto a lane of the 16-bit word. Word transfers are checked for alignment before any bus activity starts. When handshaking is on, each completed command gives a one-cycle acknowledge pulse.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset `cmd_ready_o` is 1, `hs_en_o` is 0 (handshake off), and `bus_req_o`, `ack_o`, `bg_req_o`, `rsp_valid_o`, `err_align_o` and `err_illegal_o` are all 0.
- R2: An opcode with bits [7:6]=11, bit 4=0 and bits [1:0]=00 is a memory command. Bit 5 set means read (0xE0, 0xE4, 0xE8, 0xEC). An accepted aligned read raises `bus_req_o` with `bus_we_o`=0 in the cycle after acceptance. The read data appears on `rsp_data_o` with a one-cycle `rsp_valid_o` in the cycle after the cycle in which `bus_done_i` is sampled high.
- R3: Bit 5 clear means write (0xC0, 0xC4, 0xC8, 0xCC). An accepted aligned write raises `bus_req_o` with `bus_we_o`=1, and `bus_wdata_o` equals the command data. A write produces no `rsp_valid_o`.
- R4: Opcode bit 3 selects a word access, and bit 3 clear selects a byte access. `bus_addr_o` is the command address with bit 0 cleared. A word access gives `bus_be_o`=11. A byte access at an odd address gives `bus_be_o`=01 (low byte). A byte access at an even address gives 10 (high byte). Read data returns in that same lane, and the other lane reads as zero.
- R5: `bus_win_o` equals opcode bit 2 during the transfer. It is 1 for 0xE4, 0xEC, 0xC4 and 0xCC, and 0 for the plain variants.
- R6: A word command with an odd address pulses `err_align_o` in the cycle after acceptance. It makes no bus request and gives no acknowledge and no response.
- R7: Any opcode outside the eleven defined ones pulses `err_illegal_o` in the cycle after acceptance. It leaves the handshake state unchanged and makes no bus request and no acknowledge.
- R8: Opcode 0xD5 sets `hs_en_o` and pulses `ack_o`, both in the cycle after acceptance. Opcode 0xD6 clears `hs_en_o` and gives no acknowledge.
- R9: While the handshake is on, every read and write pulses `ack_o` once, in the cycle after `bus_done_i` is sampled. While it is off, no memory command pulses `ack_o`.
- R10: Opcode 0x90 with `dbg_enable_i`=0 has no effect. With `dbg_enable_i`=1 it raises `bg_req_o` in the cycle after acceptance and holds it until `bg_active_i` is sampled high. In the next cycle `bg_req_o` falls, and `ack_o` pulses if the handshake is on.
- R11: While a transfer is pending, `bus_req_o` and all bus fields stay stable until `bus_done_i`, and `cmd_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 8 | Command opcode |
| cmd_addr_i | input | 16 | Command address |
| cmd_wdata_i | input | 16 | Command write data |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| dbg_enable_i | input | 1 | Debug feature enabled |
| bg_active_i | input | 1 | Processor is in background mode |
| bg_req_o | output | 1 | Request to enter background mode |
| hs_en_o | output | 1 | Completion handshake enabled |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_data_o | output | 16 | Read data, lane-steered |
| err_align_o | output | 1 | Misaligned word command pulse |
| err_illegal_o | output | 1 | Unknown opcode pulse |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Transfer is a write |
| bus_win_o | output | 1 | Debug window overlays the map |
| bus_addr_o | output | 16 | Word-aligned transfer address |
| bus_be_o | output | 2 | Byte lane enables, bit 1 = high byte |
| bus_wdata_o | output | 16 | Write data |
| bus_done_i | input | 1 | Transfer completes this cycle |
| bus_rdata_i | input | 16 | Read data, valid with bus_done_i |

## Verification
Control outcomes fall due one cycle after the accepting edge. These are the bus request, error pulses, handshake changes, the 0xD5 acknowledge and the background request. Completion outcomes fall due one cycle after the edge that samples `bus_done_i` or `bg_active_i`: read data, the memory acknowledge and the drop of the background request. The bench plays the bus and the processor itself, with random latencies. It numbers every falling edge after acceptance and records the cycle in which it raised each completion input. It then compares each pulse's recorded cycle with the cycle the requirement predicts, rather than only checking that the pulse appeared.

// File: rtl/dce_pkg.sv
package dce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_BG   = 2'd2
    } dce_state_e;

    typedef struct packed {
        logic mem;     // memory read or write
        logic rd;      // read when set
        logic word;    // word access
        logic win;     // debug window in map
        logic bg;      // enter background
        logic hs_on;   // enable handshake
        logic hs_off;  // disable handshake
        logic bad;     // unknown opcode
    } dce_dec_t;

    localparam logic [7:0] OPC_BG     = 8'h90;
    localparam logic [7:0] OPC_HS_ON  = 8'hD5;
    localparam logic [7:0] OPC_HS_OFF = 8'hD6;

endpackage

// File: rtl/dce_decode.sv
module dce_decode
    import dce_pkg::*;
(
    input  logic [7:0] op_i,
    output dce_dec_t   dec_o
);

    always_comb begin
        dec_o = '0;
        if (op_i[7:6] == 2'b11 && !op_i[4] && op_i[1:0] == 2'b00) begin
            dec_o.mem  = 1'b1;
            dec_o.rd   = op_i[5];
            dec_o.word = op_i[3];
            dec_o.win  = op_i[2];
        end else if (op_i == OPC_BG) begin
            dec_o.bg = 1'b1;
        end else if (op_i == OPC_HS_ON) begin
            dec_o.hs_on = 1'b1;
        end else if (op_i == OPC_HS_OFF) begin
            dec_o.hs_off = 1'b1;
        end else begin
            dec_o.bad = 1'b1;
        end
    end

endmodule

// File: rtl/dce_lanes.sv
module dce_lanes #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                word_i,
    output logic [DATA_W/8-1:0] be_o,
    output logic [ADDR_W-1:0]   waddr_o,
    output logic                misalign_o,
    input  logic [DATA_W/8-1:0] ret_be_i,
    input  logic [DATA_W-1:0]   ret_raw_i,
    output logic [DATA_W-1:0]   ret_data_o
);

    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = (NB > 1) ? $clog2(NB) : 1;

    logic [OFF_W-1:0] off;

    assign off        = addr_i[OFF_W-1:0];
    assign misalign_o = word_i && (off != '0);
    assign waddr_o    = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // lowest address maps to the most significant lane
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign be_o[i] = word_i || (off == OFF_W'(NB - 1 - i));
        assign ret_data_o[i*8 +: 8] = ret_be_i[i] ? ret_raw_i[i*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dce_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid_i,
    input  logic [7:0]          cmd_op_i,
    input  logic [ADDR_W-1:0]   cmd_addr_i,
    input  logic [DATA_W-1:0]   cmd_wdata_i,
    output logic                cmd_ready_o,
    input  logic                dbg_enable_i,
    input  logic                bg_active_i,
    output logic                bg_req_o,
    output logic                hs_en_o,
    output logic                ack_o,
    output logic                rsp_valid_o,
    output logic [DATA_W-1:0]   rsp_data_o,
    output logic                err_align_o,
    output logic                err_illegal_o,
    output logic                bus_req_o,
    output logic                bus_we_o,
    output logic                bus_win_o,
    output logic [ADDR_W-1:0]   bus_addr_o,
    output logic [DATA_W/8-1:0] bus_be_o,
    output logic [DATA_W-1:0]   bus_wdata_o,
    input  logic                bus_done_i,
    input  logic [DATA_W-1:0]   bus_rdata_i
);

    localparam int NB = DATA_W / 8;

    typedef struct packed {
        dce_state_e        st;
        logic              hs_en;
        logic              ack;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              err_align;
        logic              err_ill;
        logic              bg_req;
        logic              bus_req;
        logic              bus_we;
        logic              bus_win;
        logic [ADDR_W-1:0] bus_addr;
        logic [NB-1:0]     bus_be;
        logic [DATA_W-1:0] bus_wdata;
    } eng_t;

    eng_t s_d, s_q;

    dce_dec_t          dec;
    logic [NB-1:0]     req_be;
    logic [ADDR_W-1:0] req_addr;
    logic              req_misalign;
    logic [DATA_W-1:0] ret_data;

    dce_decode u_decode (
        .op_i  (cmd_op_i),
        .dec_o (dec)
    );

    dce_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lanes (
        .addr_i     (cmd_addr_i),
        .word_i     (dec.word),
        .be_o       (req_be),
        .waddr_o    (req_addr),
        .misalign_o (req_misalign),
        .ret_be_i   (s_q.bus_be),
        .ret_raw_i  (bus_rdata_i),
        .ret_data_o (ret_data)
    );

    always_comb begin
        s_d           = s_q;
        s_d.ack       = 1'b0;
        s_d.rsp_valid = 1'b0;
        s_d.err_align = 1'b0;
        s_d.err_ill   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    if (dec.bad) begin
                        s_d.err_ill = 1'b1;
                    end else if (dec.hs_on) begin
                        s_d.hs_en = 1'b1;
                        s_d.ack   = 1'b1;
                    end else if (dec.hs_off) begin
                        s_d.hs_en = 1'b0;
                    end else if (dec.bg) begin
                        if (dbg_enable_i) begin
                            s_d.bg_req = 1'b1;
                            s_d.st     = ST_BG;
                        end
                    end else if (req_misalign) begin
                        s_d.err_align = 1'b1;
                    end else begin
                        s_d.st        = ST_BUS;
                        s_d.bus_req   = 1'b1;
                        s_d.bus_we    = !dec.rd;
                        s_d.bus_win   = dec.win;
                        s_d.bus_addr  = req_addr;
                        s_d.bus_be    = req_be;
                        s_d.bus_wdata = cmd_wdata_i;
                    end
                end
            end
            ST_BUS: begin
                if (bus_done_i) begin
                    s_d.st      = ST_IDLE;
                    s_d.bus_req = 1'b0;
                    s_d.bus_win = 1'b0;
                    s_d.ack     = s_q.hs_en;
                    if (!s_q.bus_we) begin
                        s_d.rsp_valid = 1'b1;
                        s_d.rsp_data  = ret_data;
                    end
                end
            end
            ST_BG: begin
                if (bg_active_i) begin
                    s_d.st     = ST_IDLE;
                    s_d.bg_req = 1'b0;
                    s_d.ack    = s_q.hs_en;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready_o   = (s_q.st == ST_IDLE);
    assign bg_req_o      = s_q.bg_req;
    assign hs_en_o       = s_q.hs_en;
    assign ack_o         = s_q.ack;
    assign rsp_valid_o   = s_q.rsp_valid;
    assign rsp_data_o    = s_q.rsp_data;
    assign err_align_o   = s_q.err_align;
    assign err_illegal_o = s_q.err_ill;
    assign bus_req_o     = s_q.bus_req;
    assign bus_we_o      = s_q.bus_we;
    assign bus_win_o     = s_q.bus_win;
    assign bus_addr_o    = s_q.bus_addr;
    assign bus_be_o      = s_q.bus_be;
    assign bus_wdata_o   = s_q.bus_wdata;

    // R11: pending transfer holds its fields
    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_addr_o)
            && $stable(bus_be_o) && $stable(bus_we_o) && $stable(bus_win_o));

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> !cmd_ready_o);

    // R9: acknowledge follows completion when handshake is on
    p_ack_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_done_i && hs_en_o |=> ack_o);

    // R8: no acknowledge while handshake is off
    p_ack_needs_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> hs_en_o);

    // R6: misaligned command is silent on the bus
    p_misalign_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_align_o |-> !bus_req_o && !ack_o);

    // R7: outcomes of one command never overlap
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid_o, err_align_o, err_illegal_o}));

    // R10: background request holds until the processor answers
    p_bg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bg_req_o && !bg_active_i |=> bg_req_o);

    // R4: one lane for bytes, every lane for words
    p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> ($countones(bus_be_o) == 1 || bus_be_o == '1));

endmodule

// File: tb/dbg_cmd_engine_tb.sv
module dbg_cmd_engine_tb;

    localparam int WIN = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [15:0] cmd_addr = 16'h0;
    logic [15:0] cmd_wdata = 16'h0;
    logic        cmd_ready;
    logic        dbg_enable = 1'b0;
    logic        bg_active = 1'b0;
    logic        bg_req, hs_en, ack, rsp_valid, err_align, err_illegal;
    logic [15:0] rsp_data;
    logic        bus_req, bus_we, bus_win;
    logic [15:0] bus_addr, bus_wdata;
    logic [1:0]  bus_be;
    logic        bus_done = 1'b0;
    logic [15:0] bus_rdata = 16'h0;

    int checks = 0;
    int errors = 0;
    bit hs_model = 1'b0;

    always #5 clk = ~clk;

    dbg_cmd_engine u_dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid_i (cmd_valid), .cmd_op_i (cmd_op), .cmd_addr_i (cmd_addr),
        .cmd_wdata_i (cmd_wdata), .cmd_ready_o (cmd_ready),
        .dbg_enable_i (dbg_enable), .bg_active_i (bg_active), .bg_req_o (bg_req),
        .hs_en_o (hs_en), .ack_o (ack), .rsp_valid_o (rsp_valid), .rsp_data_o (rsp_data),
        .err_align_o (err_align), .err_illegal_o (err_illegal),
        .bus_req_o (bus_req), .bus_we_o (bus_we), .bus_win_o (bus_win),
        .bus_addr_o (bus_addr), .bus_be_o (bus_be), .bus_wdata_o (bus_wdata),
        .bus_done_i (bus_done), .bus_rdata_i (bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_model(input logic [15:0] a, input logic w);
        return (a ^ 16'h3C96) + (w ? 16'h0101 : 16'h0000) + {a[7:0], 8'h00};
    endfunction

    function automatic bit op_known(input logic [7:0] op);
        case (op)
            8'h90, 8'hD5, 8'hD6, 8'hE0, 8'hE4, 8'hE8, 8'hEC,
            8'hC0, 8'hC4, 8'hC8, 8'hCC: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit op_mem(input logic [7:0] op);
        case (op)
            8'hE0, 8'hE4, 8'hE8, 8'hEC, 8'hC0, 8'hC4, 8'hC8, 8'hCC: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_cmd(input logic [7:0] op, input logic [15:0] a,
                           input logic [15:0] wd, input bit den);
        int lat, bglat;
        int ack_cnt = 0, ack_c = 0, rsp_cnt = 0, rsp_c = 0;
        int ea_cnt = 0, ea_c = 0, ei_cnt = 0, ei_c = 0;
        int starts = 0, start_c = 0, done_c = 0, bga_c = 0, bg_first = 0, bg_last = 0;
        bit done_seen = 0, bga = 0, prev_req = 0, ready1 = 0, hs1 = 0;
        logic [15:0] r_data = 0, c_addr = 0, c_wdata = 0;
        logic [1:0]  c_be = 0;
        logic        c_we = 0, c_win = 0;
        bit is_rd, is_word, win, hs_before;
        logic [15:0] exp_rd;
        logic [1:0]  exp_be;

        chk(cmd_ready == 1'b1, "R11 ready when idle", cmd_ready, 1);
        dbg_enable = den;
        cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat   = $urandom_range(0, 3);
        bglat = $urandom_range(0, 3);
        hs_before = hs_model;

        for (int c = 1; c <= WIN; c++) begin
            if (ack)         begin ack_cnt++; ack_c = c; end
            if (rsp_valid)   begin rsp_cnt++; rsp_c = c; r_data = rsp_data; end
            if (err_align)   begin ea_cnt++; ea_c = c; end
            if (err_illegal) begin ei_cnt++; ei_c = c; end
            if (bus_req && !prev_req) begin
                starts++; start_c = c;
                c_addr = bus_addr; c_be = bus_be; c_we = bus_we;
                c_win = bus_win; c_wdata = bus_wdata;
            end
            if (c == 1) begin ready1 = cmd_ready; hs1 = hs_en; end
            if (bg_req) begin
                if (bg_first == 0) bg_first = c;
                bg_last = c;
            end
            prev_req = bus_req;
            bus_done = 1'b0;
            if (bus_req && !done_seen) begin
                if (lat == 0) begin
                    bus_done = 1'b1; bus_rdata = mem_model(bus_addr, bus_win);
                    done_c = c; done_seen = 1;
                end else lat--;
            end
            if (bg_req && !bga) begin
                if (bglat == 0) begin bg_active = 1'b1; bga = 1; bga_c = c; end
                else bglat--;
            end
            @(negedge clk);
        end
        bus_done = 1'b0;
        bg_active = 1'b0;
        @(negedge clk);

        if (!op_known(op)) begin
            chk(ei_cnt == 1 && ei_c == 1, "R7 illegal flag at cycle 1", ei_c, 1);
            chk(starts == 0 && ack_cnt == 0, "R7 illegal no bus/ack", starts + ack_cnt, 0);
            chk(hs_en == hs_before, "R7 handshake unchanged", hs_en, hs_before);
        end else if (op == 8'hD5) begin
            hs_model = 1;
            chk(hs1 == 1'b1, "R8 enable sets handshake", hs1, 1);
            chk(ack_cnt == 1 && ack_c == 1, "R8 enable ack at cycle 1", ack_c, 1);
        end else if (op == 8'hD6) begin
            hs_model = 0;
            chk(hs1 == 1'b0, "R8 disable clears handshake", hs1, 0);
            chk(ack_cnt == 0, "R8 disable gives no ack", ack_cnt, 0);
        end else if (op == 8'h90) begin
            if (!den) begin
                chk(bg_first == 0 && ack_cnt == 0, "R10 disabled background ignored",
                    bg_first + ack_cnt, 0);
                chk(ready1 == 1'b1, "R10 disabled background stays ready", ready1, 1);
            end else begin
                chk(bg_first == 1, "R10 request at cycle 1", bg_first, 1);
                chk(bg_last == bga_c, "R10 request drops after active", bg_last, bga_c);
                chk(ack_cnt == (hs_model ? 1 : 0), "R10 ack count", ack_cnt, hs_model);
                if (hs_model)
                    chk(ack_c == bga_c + 1, "R10 ack timing", ack_c, bga_c + 1);
            end
        end else if (op_mem(op)) begin
            is_rd   = op[5];
            is_word = op[3];
            win     = op[2];
            if (is_word && a[0]) begin
                chk(ea_cnt == 1 && ea_c == 1, "R6 align flag at cycle 1", ea_c, 1);
                chk(starts == 0 && ack_cnt == 0 && rsp_cnt == 0, "R6 misaligned silent",
                    starts + ack_cnt + rsp_cnt, 0);
            end else begin
                exp_be = is_word ? 2'b11 : (a[0] ? 2'b01 : 2'b10);
                chk(starts == 1 && start_c == 1, "R2 R3 bus request at cycle 1", start_c, 1);
                chk(ready1 == 1'b0, "R11 not ready while busy", ready1, 0);
                chk(c_addr == {a[15:1], 1'b0}, "R4 bus address", c_addr, {a[15:1], 1'b0});
                chk(c_be == exp_be, "R4 byte lanes", c_be, exp_be);
                chk(c_win == win, "R5 window select", c_win, win);
                chk(c_we == !is_rd, "R2 R3 direction", c_we, !is_rd);
                chk(ea_cnt == 0 && ei_cnt == 0, "R6 R7 no error on legal", ea_cnt + ei_cnt, 0);
                if (is_rd) begin
                    exp_rd = mem_model({a[15:1], 1'b0}, win);
                    if (exp_be == 2'b01) exp_rd[15:8] = 8'h00;
                    if (exp_be == 2'b10) exp_rd[7:0]  = 8'h00;
                    chk(rsp_cnt == 1 && rsp_c == done_c + 1, "R2 response timing",
                        rsp_c, done_c + 1);
                    chk(r_data == exp_rd, "R2 R4 read data", r_data, exp_rd);
                end else begin
                    chk(c_wdata == wd, "R3 write data", c_wdata, wd);
                    chk(rsp_cnt == 0, "R3 no response on write", rsp_cnt, 0);
                end
                chk(ack_cnt == (hs_model ? 1 : 0), "R9 ack count", ack_cnt, hs_model);
                if (hs_model)
                    chk(ack_c == done_c + 1, "R9 ack timing", ack_c, done_c + 1);
            end
        end
        chk(hs_en == hs_model, "R8 handshake state", hs_en, hs_model);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] ops [11];
        ops = '{8'hE0, 8'hE4, 8'hE8, 8'hEC, 8'hC0, 8'hC4, 8'hC8, 8'hCC,
                8'h90, 8'hD5, 8'hD6};
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
        chk(hs_en == 1'b0, "R1 handshake off after reset", hs_en, 0);
        chk({bus_req, ack, bg_req, rsp_valid, err_align, err_illegal} == 6'b0,
            "R1 outputs idle after reset",
            {bus_req, ack, bg_req, rsp_valid, err_align, err_illegal}, 0);

        run_cmd(8'hE8, 16'h1234, 16'h0, 1'b0);
        run_cmd(8'hD6, 16'h0, 16'h0, 1'b0);
        run_cmd(8'hC8, 16'h2000, 16'hBEEF, 1'b0);
        run_cmd(8'hD5, 16'h0, 16'h0, 1'b0);
        run_cmd(8'hE4, 16'h0007, 16'h0, 1'b0);
        run_cmd(8'hE0, 16'h0100, 16'h0, 1'b0);
        run_cmd(8'hC4, 16'h00FF, 16'hA55A, 1'b0);
        run_cmd(8'hC0, 16'h4002, 16'h1357, 1'b0);
        run_cmd(8'hCC, 16'h0004, 16'hFACE, 1'b0);
        run_cmd(8'hEC, 16'h000A, 16'h0, 1'b0);
        run_cmd(8'hE8, 16'h0003, 16'h0, 1'b0);
        run_cmd(8'hCC, 16'h0011, 16'h7777, 1'b0);
        run_cmd(8'h00, 16'h0, 16'h0, 1'b0);
        run_cmd(8'hFF, 16'h0, 16'h0, 1'b0);
        run_cmd(8'h90, 16'h0, 16'h0, 1'b0);
        run_cmd(8'h90, 16'h0, 16'h0, 1'b1);
        run_cmd(8'hD6, 16'h0, 16'h0, 1'b0);
        run_cmd(8'h90, 16'h0, 16'h0, 1'b1);
        run_cmd(8'hE4, 16'hFF01, 16'h0, 1'b0);

        for (int n = 0; n < 160; n++) begin
            int k;
            logic [7:0]  op;
            logic [15:0] a;
            k = $urandom_range(0, 11);
            if (k == 11) begin
                do op = 8'($urandom); while (op_known(op));
            end else op = ops[k];
            a = 16'($urandom);
            run_cmd(op, a, 16'($urandom), 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule